// File: doc/BRIEF.md
# Security-Tagged Cache Tag Lookup

This block holds the tags of a set-associative cache with 32-byte lines and answers whether a request hits. Every entry stores a security attribute (`ns`, set for non-secure) beside the address tag. That attribute takes part in the compare as if it were one more address bit. A secure copy and a non-secure copy of the same physical address therefore occupy separate lines and never hit each other.

Requests arrive on one valid/ready channel carrying an operation code, an address, the security attribute, a way number and write qualifiers. A lookup compares all ways of the indexed set in parallel. Its result appears one cycle later on plain status pins. A fill overwrites the way chosen by the requester, and the choice of victim is made outside this block. When the overwritten entry was valid and dirty, the block raises an eviction on a second valid/ready channel. The eviction carries the old line address and the security attribute that was stored with the line. The write-back therefore keeps the security level of the data, not that of the requester that caused it. A maintenance command clears one way in every set, one set per clock. While it runs, `busy` is high.

Back-pressure rules: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while an invalidate sweep runs and while an eviction waits to be taken. The eviction transfers on an edge where `evict_valid` and `evict_ready` are both high. Until that edge its address and attribute stay constant.

Top module: `sec_tag_lookup`

## Requirements
- R1: After reset every entry is invalid and clean, `res_valid`, `res_hit`, `evict_valid` and `busy` are low, `req_ready` is high, and every lookup misses.
- R2: Address bits [4:0] are the byte offset and take no part in the compare. The set index is bits [5+IDX_W-1:5] and the tag is the bits above the index.
- R3: A lookup hits only on a valid entry whose tag equals the request tag and whose stored `ns` equals `req_ns`. The same address with the other `ns` value misses.
- R4: A lookup (`req_op` = 2'b00) accepted on an edge gives, on the next edge, `res_valid`=1, `res_hit`, and `res_way` as the binary number of the hitting way (lowest matching way if several, 0 on a miss). `res_valid` is low in any cycle that does not follow an accepted lookup.
- R5: A fill (`req_op` = 2'b01) writes a valid entry with the request tag and `ns` into way `req_way` of the indexed set, and a later matching lookup reports that way.
- R6: A fill whose target entry was valid and dirty raises `evict_valid` on the next edge. It presents `evict_addr` = {old tag, index, 5'b0} and `evict_ns` = the stored `ns`. A fill over a clean or invalid entry raises no eviction.
- R7: An entry becomes dirty only when written with `req_write`=1 and `req_wb`=1, either by a fill or by a lookup that hits. Reads and write-through writes (`req_wb`=0) leave it clean.
- R8: While `evict_valid` is high and `evict_ready` is low, the eviction outputs hold and `req_ready` stays low. An eviction clears on the edge where it is taken.
- R9: An invalidate (`req_op` = 2'b10) clears way `req_way` in every set without write-back. `busy` is high for exactly SETS cycles after acceptance with `req_ready` low, and the other ways are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 00 lookup, 01 fill, 10 invalidate way, 11 no operation |
| req_addr | input | ADDR_W | Byte address |
| req_ns | input | 1 | Security attribute of the request (1 = non-secure) |
| req_way | input | log2(WAYS) | Way for fill or invalidate |
| req_write | input | 1 | Request is a write |
| req_wb | input | 1 | Write-back mode (0 = write-through) |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup hit |
| res_way | output | log2(WAYS) | Hitting way |
| busy | output | 1 | Invalidate sweep in progress |
| evict_valid | output | 1 | Eviction write-back pending |
| evict_ready | input | 1 | Eviction taken |
| evict_addr | output | ADDR_W | Line address of the evicted entry |
| evict_ns | output | 1 | Stored security attribute of the evicted entry |

## Verification
The hardest case to reach from the ports is an eviction whose stored security attribute differs from that of the fill that causes it. To get there, a line must first be filled or write-hit in write-back mode under one attribute. The same way must then be refilled under the other attribute while the eviction channel is held back. Directed sequences build this case under both attribute orders and stall `evict_ready` for several cycles. Random traffic then draws tags from a pool of four per set, so hits, dirty refills and secure/non-secure aliases of one address recur often. Invalidates mixed into that traffic clear dirty lines that the reference model must then treat as gone.

// File: rtl/stl_pkg.sv
package stl_pkg;
  localparam int LINE_OFF_W = 5;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'b00,
    OP_FILL   = 2'b01,
    OP_INVAL  = 2'b10,
    OP_NONE   = 2'b11
  } stl_op_e;
endpackage

// File: rtl/stl_tag_array.sv
module stl_tag_array #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int ENT_W = 24,
  parameter int IDX_W = 6,
  parameter int WAY_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IDX_W-1:0]      w_idx,
  input  logic [WAY_W-1:0]      w_way,
  input  logic [ENT_W-1:0]      w_ent,
  input  logic [IDX_W-1:0]      r_idx,
  output logic [WAYS*ENT_W-1:0] r_set
);
  logic [WAYS*ENT_W-1:0] mem [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) mem[s] <= '0;
    end else if (we) begin
      mem[w_idx][w_way*ENT_W +: ENT_W] <= w_ent;
    end
  end

  assign r_set = mem[r_idx];
endmodule

// File: rtl/stl_match.sv
module stl_match #(
  parameter int WAYS  = 8,
  parameter int ENT_W = 24,
  parameter int TAG_W = 21,
  parameter int WAY_W = 3
) (
  input  logic [WAYS*ENT_W-1:0] set_ents,
  input  logic [TAG_W-1:0]      tag,
  input  logic                  ns,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  // entry layout: [ENT_W-1] valid, [ENT_W-2] dirty, [ENT_W-3] ns, [TAG_W-1:0] tag
  logic [WAYS-1:0] way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic [ENT_W-1:0] e;
    assign e = set_ents[w*ENT_W +: ENT_W];
    assign way_hit[w] = e[ENT_W-1] && (e[ENT_W-3] == ns) && (e[TAG_W-1:0] == tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |way_hit;
endmodule

// File: rtl/stl_sweep.sv
module stl_sweep #(
  parameter int SETS  = 64,
  parameter int IDX_W = 6,
  parameter int WAY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WAY_W-1:0] start_way,
  output logic             busy,
  output logic             we,
  output logic [IDX_W-1:0] idx,
  output logic [WAY_W-1:0] way
);
  logic [IDX_W-1:0] cnt;
  logic [WAY_W-1:0] way_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      way_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= '0;
      way_q <= start_way;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == IDX_W'(SETS - 1)) busy <= 1'b0;
    end
  end

  assign we  = busy;
  assign idx = cnt;
  assign way = way_q;
endmodule

// File: rtl/sec_tag_lookup.sv
module sec_tag_lookup #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 64,
  parameter int WAYS   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_op,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_ns,
  input  logic [$clog2(WAYS)-1:0]  req_way,
  input  logic                     req_write,
  input  logic                     req_wb,
  output logic                     res_valid,
  output logic                     res_hit,
  output logic [$clog2(WAYS)-1:0]  res_way,
  output logic                     busy,
  output logic                     evict_valid,
  input  logic                     evict_ready,
  output logic [ADDR_W-1:0]        evict_addr,
  output logic                     evict_ns
);
  import stl_pkg::*;

  localparam int OFF_W = LINE_OFF_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int ENT_W = TAG_W + 3;
  localparam int V_B   = ENT_W - 1;
  localparam int D_B   = ENT_W - 2;
  localparam int N_B   = ENT_W - 3;

  logic [IDX_W-1:0]      r_idx;
  logic [TAG_W-1:0]      r_tag;
  logic [WAYS*ENT_W-1:0] r_set;
  logic [ENT_W-1:0]      old_ent, hit_ent;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way;
  logic                  acc, acc_lookup, acc_fill, acc_inval;
  logic                  we;
  logic [IDX_W-1:0]      w_idx;
  logic [WAY_W-1:0]      w_way;
  logic [ENT_W-1:0]      w_ent;
  logic                  sw_we;
  logic [IDX_W-1:0]      sw_idx;
  logic [WAY_W-1:0]      sw_way;
  logic                  unused_off;

  assign unused_off = ^req_addr[OFF_W-1:0];
  assign r_idx      = req_addr[OFF_W +: IDX_W];
  assign r_tag      = req_addr[ADDR_W-1 -: TAG_W];

  assign req_ready  = !busy && !evict_valid;
  assign acc        = req_valid && req_ready;
  assign acc_lookup = acc && (req_op == OP_LOOKUP);
  assign acc_fill   = acc && (req_op == OP_FILL);
  assign acc_inval  = acc && (req_op == OP_INVAL);

  stl_tag_array #(
    .SETS(SETS), .WAYS(WAYS), .ENT_W(ENT_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .we(we), .w_idx(w_idx), .w_way(w_way),
    .w_ent(w_ent), .r_idx(r_idx), .r_set(r_set)
  );

  stl_match #(
    .WAYS(WAYS), .ENT_W(ENT_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_match (
    .set_ents(r_set), .tag(r_tag), .ns(req_ns), .hit(hit), .hit_way(hit_way)
  );

  stl_sweep #(
    .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(acc_inval), .start_way(req_way),
    .busy(busy), .we(sw_we), .idx(sw_idx), .way(sw_way)
  );

  assign old_ent = r_set[req_way*ENT_W +: ENT_W];
  assign hit_ent = r_set[hit_way*ENT_W +: ENT_W];

  // single write port: sweep and accepted requests never coincide
  always_comb begin
    we    = 1'b0;
    w_idx = r_idx;
    w_way = req_way;
    w_ent = '0;
    if (sw_we) begin
      we    = 1'b1;
      w_idx = sw_idx;
      w_way = sw_way;
    end else if (acc_fill) begin
      we    = 1'b1;
      w_ent = {1'b1, req_write && req_wb, req_ns, r_tag};
    end else if (acc_lookup && hit && req_write && req_wb) begin
      we         = 1'b1;
      w_way      = hit_way;
      w_ent      = hit_ent;
      w_ent[D_B] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_way   <= '0;
    end else begin
      res_valid <= acc_lookup;
      res_hit   <= acc_lookup && hit;
      res_way   <= (acc_lookup && hit) ? hit_way : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evict_valid <= 1'b0;
      evict_addr  <= '0;
      evict_ns    <= 1'b0;
    end else if (acc_fill && old_ent[V_B] && old_ent[D_B]) begin
      evict_valid <= 1'b1;
      evict_addr  <= {old_ent[TAG_W-1:0], r_idx, {OFF_W{1'b0}}};
      evict_ns    <= old_ent[N_B];
    end else if (evict_ready) begin
      evict_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stl_check.sv
module stl_check #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              res_valid,
  input logic              res_hit,
  input logic              busy,
  input logic              evict_valid,
  input logic              evict_ready,
  input logic [ADDR_W-1:0] evict_addr,
  input logic              evict_ns
);
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r9_busy_from_inval: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready && req_op == 2'b10));

  a_r8_evict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid && !evict_ready |=> evict_valid && $stable(evict_addr) && $stable(evict_ns));

  a_r8_evict_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> !req_ready);

  a_r6_evict_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evict_valid) |-> $past(req_valid && req_ready && req_op == 2'b01));

  a_r6_evict_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> evict_addr[4:0] == 5'd0);

  a_r4_res_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid && req_ready && req_op == 2'b00));

  a_r4_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);
endmodule

bind sec_tag_lookup stl_check #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .res_valid(res_valid), .res_hit(res_hit), .busy(busy),
  .evict_valid(evict_valid), .evict_ready(evict_ready),
  .evict_addr(evict_addr), .evict_ns(evict_ns)
);

// File: tb/sim_sec_tag_lookup.sv
module sim_sec_tag_lookup;
  localparam int ADDR_W = 32;
  localparam int SETS   = 16;
  localparam int WAYS   = 8;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - 5 - IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'b00;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ns = 1'b0;
  logic [WAY_W-1:0] req_way = '0;
  logic req_write = 1'b0;
  logic req_wb = 1'b0;
  logic res_valid, res_hit;
  logic [WAY_W-1:0] res_way;
  logic busy, evict_valid, evict_ns;
  logic evict_ready = 1'b0;
  logic [ADDR_W-1:0] evict_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit m_v [SETS][WAYS];
  bit m_d [SETS][WAYS];
  bit m_n [SETS][WAYS];
  logic [TAG_W-1:0] m_t [SETS][WAYS];

  always #4 clk = ~clk;

  sec_tag_lookup #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_ns(req_ns), .req_way(req_way),
    .req_write(req_write), .req_wb(req_wb), .res_valid(res_valid),
    .res_hit(res_hit), .res_way(res_way), .busy(busy),
    .evict_valid(evict_valid), .evict_ready(evict_ready),
    .evict_addr(evict_addr), .evict_ns(evict_ns)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] t,
                                           input int idx, input int off);
    return {t, IDX_W'(idx), 5'(off)};
  endfunction

  function automatic int find(input int idx, input logic [TAG_W-1:0] t, input bit ns);
    for (int w = 0; w < WAYS; w++)
      if (m_v[idx][w] && m_t[idx][w] == t && m_n[idx][w] == ns) return w;
    return -1;
  endfunction

  task automatic send(input logic [1:0] op, input logic [ADDR_W-1:0] a, input bit ns,
                      input int way, input bit wr, input bit wb);
    @(negedge clk);
    req_op = op; req_addr = a; req_ns = ns; req_way = WAY_W'(way);
    req_write = wr; req_wb = wb; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic lookup(input logic [ADDR_W-1:0] a, input bit ns, input bit wr,
                        input bit wb, input string req);
    int idx = int'(a[5 +: IDX_W]);
    logic [TAG_W-1:0] t = a[ADDR_W-1 -: TAG_W];
    int w = find(idx, t, ns);
    send(2'b00, a, ns, 0, wr, wb);
    chk(req, "res_valid", res_valid, 1);
    chk(req, "res_hit", res_hit, w >= 0);
    chk(req, "res_way", res_way, (w >= 0) ? w : 0);
    if (w >= 0 && wr && wb) m_d[idx][w] = 1'b1;
  endtask

  task automatic fill(input logic [ADDR_W-1:0] a, input bit ns, input int way,
                      input bit wr, input bit wb, input int hold);
    int idx = int'(a[5 +: IDX_W]);
    bit ev = m_v[idx][way] && m_d[idx][way];
    logic [ADDR_W-1:0] ea = {m_t[idx][way], IDX_W'(idx), 5'd0};
    bit en = m_n[idx][way];
    send(2'b01, a, ns, way, wr, wb);
    m_v[idx][way] = 1'b1; m_d[idx][way] = wr && wb;
    m_n[idx][way] = ns;   m_t[idx][way] = a[ADDR_W-1 -: TAG_W];
    chk("R6", "evict_valid", evict_valid, ev);
    chk("R5", "res_valid after fill", res_valid, 0);
    if (ev) begin
      chk("R6", "evict_addr", evict_addr, ea);
      chk("R6", "evict_ns", evict_ns, en);
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk("R8", "evict held", evict_valid, 1);
        chk("R8", "evict_addr stable", evict_addr, ea);
        chk("R8", "req_ready low", req_ready, 0);
      end
      evict_ready = 1'b1;
      @(negedge clk);
      evict_ready = 1'b0;
      chk("R8", "evict cleared", evict_valid, 0);
    end
  endtask

  task automatic inval(input int way);
    int n = 0;
    send(2'b10, '0, 1'b0, way, 1'b0, 1'b0);
    chk("R9", "req_ready while busy", req_ready, 0);
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R9", "busy length", n, SETS);
    for (int s = 0; s < SETS; s++) begin
      m_v[s][way] = 1'b0;
      m_d[s][way] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TAG_W-1:0] ta, tb;
    void'($urandom(32'd7));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 0; m_d[s][w] = 0; m_n[s][w] = 0; m_t[s][w] = '0;
      end
    ta = TAG_W'(23'h1a5); tb = TAG_W'(23'h3c7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "res_valid", res_valid, 0);
    chk("R1", "evict_valid", evict_valid, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "req_ready", req_ready, 1);
    lookup(mk('0, 0, 0), 1'b0, 0, 0, "R1");
    lookup(mk(ta, 5, 3), 1'b1, 0, 0, "R1");
    // R5 fill then hit, R2 offset ignored, R3 ns separation
    fill(mk(ta, 5, 0), 1'b0, 3, 0, 0, 0);
    lookup(mk(ta, 5, 0), 1'b0, 0, 0, "R5");
    lookup(mk(ta, 5, 31), 1'b0, 0, 0, "R2");
    lookup(mk(ta, 6, 0), 1'b0, 0, 0, "R2");
    lookup(mk(ta, 5, 8), 1'b1, 0, 0, "R3");
    fill(mk(ta, 5, 0), 1'b1, 4, 0, 0, 0);
    lookup(mk(ta, 5, 4), 1'b1, 0, 0, "R3");
    lookup(mk(ta, 5, 4), 1'b0, 0, 0, "R4");
    // R7 write-through keeps clean: refill gives no eviction
    lookup(mk(ta, 5, 0), 1'b0, 1, 0, "R7");
    fill(mk(tb, 5, 0), 1'b0, 3, 0, 0, 0);
    // R7 dirty by write-back fill, R6 eviction of secure line, R8 hold
    fill(mk(ta, 7, 0), 1'b0, 2, 1, 1, 0);
    fill(mk(tb, 7, 0), 1'b1, 2, 0, 0, 3);
    // R7 dirty by write-back write hit; stored ns=1 used, requester ns=0
    fill(mk(tb, 9, 0), 1'b1, 5, 0, 0, 0);
    lookup(mk(tb, 9, 12), 1'b1, 1, 1, "R7");
    fill(mk(ta, 9, 0), 1'b0, 5, 0, 0, 2);
    // R9 invalidate way 4, other ways untouched
    fill(mk(tb, 2, 0), 1'b0, 4, 1, 1, 0);
    fill(mk(tb, 2, 0), 1'b1, 6, 0, 0, 0);
    inval(4);
    lookup(mk(ta, 5, 0), 1'b1, 0, 0, "R9");
    lookup(mk(tb, 2, 0), 1'b0, 0, 0, "R9");
    lookup(mk(tb, 2, 0), 1'b1, 0, 0, "R9");
    fill(mk(ta, 2, 0), 1'b0, 4, 0, 0, 0);
    // random mix
    for (int i = 0; i < 500; i++) begin
      int r = int'($urandom_range(99));
      logic [TAG_W-1:0] t = TAG_W'($urandom_range(3));
      logic [ADDR_W-1:0] a = mk(t, int'($urandom_range(SETS - 1)), int'($urandom_range(31)));
      bit ns = 1'($urandom_range(1));
      if (r < 58) lookup(a, ns, 1'($urandom_range(1)), 1'($urandom_range(1)), "R4");
      else if (r < 97) fill(a, ns, int'($urandom_range(WAYS - 1)),
                            1'($urandom_range(1)), 1'($urandom_range(1)),
                            int'($urandom_range(2)));
      else inval(int'($urandom_range(WAYS - 1)));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule